// File: doc/BRIEF.md
# Snooping MESI Line Controller

This block keeps coherence for a small direct-mapped, write-back cache that sits on an atomic snooping bus. One port faces the processor, which issues single-word reads and writes one at a time. The other port faces the bus. Misses, ownership requests and victim write-backs go out on it. The same port watches the transactions of the other caches. The block keeps a MESI state, a tag and one data word per set.

When the block snoops a transaction, it raises an inhibit line for a fixed number of lookup cycles. It then presents its shared and dirty answers for one cycle. If it holds the block modified, it hands the data over at the same time. While the block waits for its own bus grant it keeps servicing snoops. Its outgoing command is worked out again on every cycle from the live line state. Because of this, a pending ownership upgrade becomes a read-for-ownership when another cache steals the block first. A victim write-back is dropped if a snoop has already cleaned the victim.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every set is Invalid. cpu_ready, bus_req, snp_inhibit, snp_shared and snp_dirty are all low, and the first access to any address requests the bus.
- R2: A read miss issues BusRd (out_cmd=1). The line fills as Exclusive if rsp_shared is low and as Shared if it is high, and cpu_rdata returns the filled word.
- R3: A read hit, and a write hit to an Exclusive or Modified line, complete with no bus request. A write to an Exclusive line silently makes it Modified.
- R4: A write hit to a Shared line issues BusUpgr (out_cmd=3). The line does not become Modified, and its data does not change, until the grant.
- R5: If a snooped BusRdX (2) or BusUpgr (3) to the same block arrives while the local upgrade is waiting for the grant, the copy is invalidated and the pending command becomes BusRdX.
- R6: A write miss issues BusRdX, then merges the write data and leaves the line Modified.
- R7: A snooped BusRd (1) that hits a Modified line raises snp_dirty and puts the line data on snp_flush_data. The line becomes Shared. A BusRd that hits an Exclusive line makes it Shared.
- R8: A snooped BusRdX or BusUpgr that hits a valid line invalidates it. The data is flushed with snp_dirty if the line was Modified.
- R9: A snoop raises snp_inhibit for SNP_LAT cycles, starting the cycle after snp_valid. snp_shared (set for a BusRd that hits a valid copy) and snp_dirty are valid only in the single cycle right after inhibit falls.
- R10: While bus_req is waiting for a grant, snoops are still answered and their state changes still take effect.
- R11: A miss whose set holds a Modified line with another tag first issues BusWB (4), carrying the victim address and data, and then issues the fill request.
- R12: cpu_ready is a one-cycle pulse, and only one processor request is accepted at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request strobe, taken only when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Block address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with cpu_ready |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Grant; the transaction is issued on the cycle both are high |
| out_cmd | output | 3 | Command of the pending transaction (0 none, 1 BusRd, 2 BusRdX, 3 BusUpgr, 4 BusWB) |
| out_addr | output | AW | Address of the pending transaction |
| out_data | output | DW | Write-back data |
| rsp_valid | input | 1 | Fill response for the granted BusRd or BusRdX |
| rsp_shared | input | 1 | Wired-OR shared answer from the other caches |
| rsp_data | input | DW | Fill data |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Its command, same encoding as out_cmd |
| snp_addr | input | AW | Its address |
| snp_inhibit | output | 1 | Snoop lookup in progress |
| snp_shared | output | 1 | This cache holds a copy (BusRd only) |
| snp_dirty | output | 1 | This cache supplies the data; it also strobes the flush |
| snp_flush_data | output | DW | Flushed data |

## Verification
The bench sweeps every set through read fills with and without a shared answer, then through silent and upgrade writes, snoop flushes, demotions and invalidations. It also goes after the races. One race is a snooped ownership request landing on a pending upgrade: a design without the transient rule would issue BusUpgr for data it no longer holds. Another is a snoop that cleans a dirty victim while its write-back waits: a design that latched the command would write stale data back. The last is a snoop during a pending upgrade: a design that updated the word early would answer dirty before owning the block. Each check also confirms the inhibit window and that cpu_ready lasts one cycle, so a result shown during inhibit or a held ready pulse is caught.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
   typedef enum logic [2:0] {
      CMD_NONE = 3'd0, CMD_RD = 3'd1, CMD_RDX = 3'd2, CMD_UPGR = 3'd3, CMD_WB = 3'd4
   } bus_cmd_t;
   typedef enum logic [1:0] {P_IDLE, P_CHECK, P_ARB, P_FILL} cpu_ph_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
   import mesi_pkg::*;
#(
   parameter int SETS = 4,
   parameter int IW   = 2,
   parameter int TW   = 4,
   parameter int DW   = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] c_idx,
   output mesi_t         c_st,
   output logic [TW-1:0] c_tag,
   output logic [DW-1:0] c_data,
   input  logic [IW-1:0] s_idx,
   output mesi_t         s_st,
   output logic [TW-1:0] s_tag,
   output logic [DW-1:0] s_data,
   input  logic          c_st_we,
   input  logic          c_tag_we,
   input  logic          c_data_we,
   input  mesi_t         c_wst,
   input  logic [TW-1:0] c_wtag,
   input  logic [DW-1:0] c_wdata,
   input  logic          s_we,
   input  mesi_t         s_wst
);
   mesi_t         st_arr   [SETS];
   logic [TW-1:0] tag_arr  [SETS];
   logic [DW-1:0] data_arr [SETS];

   for (genvar g = 0; g < SETS; g++) begin : g_set
      mesi_t         st_r;
      logic [TW-1:0] tag_r;
      logic [DW-1:0] data_r;
      logic          c_sel, s_sel;
      assign c_sel = (c_idx == IW'(g));
      assign s_sel = (s_idx == IW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_r   <= ST_I;
            tag_r  <= '0;
            data_r <= '0;
         end else begin
            if (s_we && s_sel)            st_r <= s_wst;
            else if (c_st_we && c_sel)    st_r <= c_wst;
            if (c_tag_we && c_sel)        tag_r  <= c_wtag;
            if (c_data_we && c_sel)       data_r <= c_wdata;
         end
      end
      assign st_arr[g]   = st_r;
      assign tag_arr[g]  = tag_r;
      assign data_arr[g] = data_r;
   end

   assign c_st   = st_arr[c_idx];
   assign c_tag  = tag_arr[c_idx];
   assign c_data = data_arr[c_idx];
   assign s_st   = st_arr[s_idx];
   assign s_tag  = tag_arr[s_idx];
   assign s_data = data_arr[s_idx];

   // R10: a snoop update and a processor state update never hit one set on one edge
   assert_single_writer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_we && c_st_we && (s_idx == c_idx)));
   // R4: data is only written together with an owned or freshly filled state
   assert_data_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      c_data_we |-> (c_st_we && c_wst != ST_I));
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
   import mesi_pkg::*;
#(
   parameter int AW      = 6,
   parameter int IW      = 2,
   parameter int TW      = 4,
   parameter int DW      = 16,
   parameter int SNP_LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          snp_valid,
   input  logic [2:0]    snp_cmd,
   input  logic [AW-1:0] snp_addr,
   output logic [IW-1:0] s_idx,
   input  mesi_t         s_st,
   input  logic [TW-1:0] s_tag,
   input  logic [DW-1:0] s_data,
   output logic          s_we,
   output mesi_t         s_wst,
   output logic          busy,
   output logic          final_cyc,
   output logic          shared_o,
   output logic          dirty_o,
   output logic [DW-1:0] flush_o
);
   localparam int CW = $clog2(SNP_LAT + 1);

   logic [CW-1:0] cnt_q;
   logic [2:0]    cmd_q;
   logic [AW-1:0] addr_q;
   logic          hit, is_rd, is_own;

   assign s_idx     = addr_q[IW-1:0];
   assign final_cyc = busy && (cnt_q == CW'(1));
   assign hit       = (s_st != ST_I) && (s_tag == addr_q[AW-1:IW]);
   assign is_rd     = (cmd_q == CMD_RD);
   assign is_own    = (cmd_q == CMD_RDX) || (cmd_q == CMD_UPGR);
   assign s_we      = final_cyc && hit && (is_rd || is_own);
   assign s_wst     = is_rd ? ST_S : ST_I;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt_q    <= '0;
         cmd_q    <= '0;
         addr_q   <= '0;
         shared_o <= 1'b0;
         dirty_o  <= 1'b0;
         flush_o  <= '0;
      end else begin
         shared_o <= 1'b0;
         dirty_o  <= 1'b0;
         if (!busy) begin
            if (snp_valid) begin
               busy   <= 1'b1;
               cnt_q  <= CW'(SNP_LAT);
               cmd_q  <= snp_cmd;
               addr_q <= snp_addr;
            end
         end else if (final_cyc) begin
            busy     <= 1'b0;
            shared_o <= hit && is_rd;
            dirty_o  <= hit && (s_st == ST_M) && (is_rd || (cmd_q == CMD_RDX));
            flush_o  <= s_data;
         end else begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
   end

   // R9: answers appear only in the cycle right after inhibit falls
   assert_answer_after_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (shared_o || dirty_o) |-> (!busy && $past(busy)));
   // R7: dirty is only raised for a line that was Modified at lookup
   assert_dirty_from_mod_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_o |-> $past(s_st == ST_M));
   // R8: an ownership snoop that hit leaves the set Invalid
   assert_own_invalidates_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (final_cyc && hit && is_own) |=> (s_st == ST_I));
endmodule

// File: rtl/mesi_cpu_ctrl.sv
module mesi_cpu_ctrl
   import mesi_pkg::*;
#(
   parameter int AW = 6,
   parameter int IW = 2,
   parameter int TW = 4,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_ready,
   output logic [DW-1:0] cpu_rdata,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [2:0]    out_cmd,
   output logic [AW-1:0] out_addr,
   output logic [DW-1:0] out_data,
   input  logic          rsp_valid,
   input  logic          rsp_shared,
   input  logic [DW-1:0] rsp_data,
   input  logic          snp_busy,
   input  logic          snp_final,
   output logic [IW-1:0] c_idx,
   input  mesi_t         c_st,
   input  logic [TW-1:0] c_tag,
   input  logic [DW-1:0] c_data,
   output logic          c_st_we,
   output logic          c_tag_we,
   output logic          c_data_we,
   output mesi_t         c_wst,
   output logic [TW-1:0] c_wtag,
   output logic [DW-1:0] c_wdata
);
   cpu_ph_t       ph_q, ph_d;
   logic          we_q, fill_x_q, fill_x_d;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          rdy_d;
   logic [DW-1:0] rdata_d;
   bus_cmd_t      cmd;
   logic          tag_eq, granted;

   assign c_idx   = addr_q[IW-1:0];
   assign tag_eq  = (c_tag == addr_q[AW-1:IW]);
   assign bus_req = (ph_q == P_ARB);
   assign granted = bus_req && bus_gnt;

   // command is re-derived each cycle from the live line state (transient upgrade)
   always_comb begin
      cmd = CMD_NONE;
      if (ph_q == P_ARB) begin
         if (we_q && tag_eq && c_st == ST_S)  cmd = CMD_UPGR;
         else if (c_st == ST_M && !tag_eq)    cmd = CMD_WB;
         else if (we_q)                       cmd = CMD_RDX;
         else                                 cmd = CMD_RD;
      end
   end

   assign out_cmd  = cmd;
   assign out_addr = (cmd == CMD_WB) ? {c_tag, c_idx} : addr_q;
   assign out_data = c_data;
   assign c_wtag   = addr_q[AW-1:IW];

   always_comb begin
      ph_d      = ph_q;
      fill_x_d  = fill_x_q;
      rdy_d     = 1'b0;
      rdata_d   = cpu_rdata;
      c_st_we   = 1'b0;
      c_tag_we  = 1'b0;
      c_data_we = 1'b0;
      c_wst     = ST_I;
      c_wdata   = wdata_q;
      unique case (ph_q)
         P_IDLE: if (cpu_req) ph_d = P_CHECK;
         P_CHECK: if (!snp_final) begin
            if (tag_eq && c_st != ST_I && (!we_q || c_st == ST_E || c_st == ST_M)) begin
               rdy_d   = 1'b1;
               rdata_d = c_data;
               ph_d    = P_IDLE;
               if (we_q) begin
                  c_st_we   = 1'b1;
                  c_data_we = 1'b1;
                  c_wst     = ST_M;
               end
            end else begin
               ph_d = P_ARB;
            end
         end
         P_ARB: if (bus_gnt) begin
            unique case (cmd)
               CMD_UPGR: begin
                  c_st_we   = 1'b1;
                  c_data_we = 1'b1;
                  c_wst     = ST_M;
                  rdy_d     = 1'b1;
                  ph_d      = P_IDLE;
               end
               CMD_WB: begin
                  c_st_we = 1'b1;
                  c_wst   = ST_I;
               end
               default: begin
                  fill_x_d = (cmd == CMD_RDX);
                  ph_d     = P_FILL;
               end
            endcase
         end
         P_FILL: if (rsp_valid) begin
            c_st_we   = 1'b1;
            c_tag_we  = 1'b1;
            c_data_we = 1'b1;
            c_wst     = fill_x_q ? ST_M : (rsp_shared ? ST_S : ST_E);
            c_wdata   = fill_x_q ? wdata_q : rsp_data;
            rdy_d     = 1'b1;
            rdata_d   = rsp_data;
            ph_d      = P_IDLE;
         end
         default: ph_d = P_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= P_IDLE;
         we_q      <= 1'b0;
         fill_x_q  <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         cpu_ready <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         ph_q      <= ph_d;
         fill_x_q  <= fill_x_d;
         cpu_ready <= rdy_d;
         cpu_rdata <= rdata_d;
         if (ph_q == P_IDLE && cpu_req) begin
            we_q    <= cpu_we;
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
         end
      end
   end

   // R12: completion is a single-cycle pulse
   assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);
   // R10: the bus is never granted to us while a snoop lookup is open
   assert_no_grant_in_snoop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_gnt |-> !snp_busy);
   // R11: a granted write-back leaves the victim set Invalid
   assert_wb_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (granted && cmd == CMD_WB) |=> (c_st == ST_I));
   // R4: an upgrade is only offered for a line still held Shared
   assert_upgr_needs_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && out_cmd == 3'(CMD_UPGR)) |-> (c_st == ST_S));
   // R2: fill data only arrives while a fill is awaited
   assert_fill_when_waiting_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (ph_q == P_FILL));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int SETS    = 4,
   parameter int AW      = 6,
   parameter int DW      = 16,
   parameter int SNP_LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_ready,
   output logic [DW-1:0] cpu_rdata,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [2:0]    out_cmd,
   output logic [AW-1:0] out_addr,
   output logic [DW-1:0] out_data,
   input  logic          rsp_valid,
   input  logic          rsp_shared,
   input  logic [DW-1:0] rsp_data,
   input  logic          snp_valid,
   input  logic [2:0]    snp_cmd,
   input  logic [AW-1:0] snp_addr,
   output logic          snp_inhibit,
   output logic          snp_shared,
   output logic          snp_dirty,
   output logic [DW-1:0] snp_flush_data
);
   localparam int IW = $clog2(SETS);
   localparam int TW = AW - IW;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (TW < 1) begin : g_bad_aw
      $error("AW must exceed the index width");
   end
   if (SNP_LAT < 1) begin : g_bad_lat
      $error("SNP_LAT must be at least 1");
   end

   logic [IW-1:0] c_idx, s_idx;
   mesi_t         c_st, s_st, c_wst, s_wst;
   logic [TW-1:0] c_tag, s_tag, c_wtag;
   logic [DW-1:0] c_data, s_data, c_wdata;
   logic          c_st_we, c_tag_we, c_data_we, s_we;
   logic          snp_final;

   mesi_line_store #(.SETS(SETS), .IW(IW), .TW(TW), .DW(DW)) u_store (
      .clk, .rst_n,
      .c_idx, .c_st, .c_tag, .c_data,
      .s_idx, .s_st, .s_tag, .s_data,
      .c_st_we, .c_tag_we, .c_data_we, .c_wst, .c_wtag, .c_wdata,
      .s_we, .s_wst
   );

   mesi_snoop_unit #(.AW(AW), .IW(IW), .TW(TW), .DW(DW), .SNP_LAT(SNP_LAT)) u_snoop (
      .clk, .rst_n,
      .snp_valid, .snp_cmd, .snp_addr,
      .s_idx, .s_st, .s_tag, .s_data, .s_we, .s_wst,
      .busy(snp_inhibit), .final_cyc(snp_final),
      .shared_o(snp_shared), .dirty_o(snp_dirty), .flush_o(snp_flush_data)
   );

   mesi_cpu_ctrl #(.AW(AW), .IW(IW), .TW(TW), .DW(DW)) u_cpu (
      .clk, .rst_n,
      .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_ready, .cpu_rdata,
      .bus_req, .bus_gnt, .out_cmd, .out_addr, .out_data,
      .rsp_valid, .rsp_shared, .rsp_data,
      .snp_busy(snp_inhibit), .snp_final,
      .c_idx, .c_st, .c_tag, .c_data,
      .c_st_we, .c_tag_we, .c_data_we, .c_wst, .c_wtag, .c_wdata
   );
endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
   localparam int LAT = 2;
   localparam logic [2:0] NONE = 3'd0, RD = 3'd1, RDX = 3'd2, UPGR = 3'd3, WB = 3'd4;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cpu_req = 0, cpu_we = 0;
   logic [5:0]  cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [15:0] cpu_rdata;
   logic        bus_req, bus_gnt = 0;
   logic [2:0]  out_cmd;
   logic [5:0]  out_addr;
   logic [15:0] out_data;
   logic        rsp_valid = 0, rsp_shared = 0;
   logic [15:0] rsp_data = '0;
   logic        snp_valid = 0;
   logic [2:0]  snp_cmd = '0;
   logic [5:0]  snp_addr = '0;
   logic        snp_inhibit, snp_shared, snp_dirty;
   logic [15:0] snp_flush_data;

   logic [15:0] mem [64];
   int total = 0, bad = 0, cyc = 0;

   always #5 clk = ~clk;

   mesi_line_ctrl #(.SETS(4), .AW(6), .DW(16), .SNP_LAT(LAT)) u0 (.*);

   function automatic logic [15:0] init_val(input int a);
      return 16'hA000 + 16'(a * 7);
   endfunction

   task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tg, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected<=50000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic pulse_req(input logic we, input logic [5:0] a, input logic [15:0] wd);
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 0;
   endtask

   task automatic wait_bus_req();
      for (int k = 0; k < 10 && !bus_req; k++) @(negedge clk);
   endtask

   task automatic complete(input logic sh, input int n, input logic [2:0] c0, input logic [2:0] c1,
                           input logic chk_rd, input logic [15:0] erd, input string tg);
      int idx = 0;
      bit got = 0;
      logic [15:0] rd = '0;
      for (int k = 0; k < 40 && !got; k++) begin
         if (cpu_ready) begin
            got = 1; rd = cpu_rdata;
         end else if (bus_req) begin
            logic [2:0]  c;
            logic [5:0]  a;
            logic [15:0] d;
            bus_gnt = 1;
            #1;
            c = out_cmd; a = out_addr; d = out_data;
            chk({tg, " bus command"}, 32'(c), (idx == 0) ? 32'(c0) : (idx == 1) ? 32'(c1) : 32'(NONE));
            @(negedge clk);
            bus_gnt = 0;
            if (c == WB) mem[a] = d;
            if (c == RD || c == RDX) begin
               rsp_valid = 1; rsp_data = mem[a]; rsp_shared = sh;
               @(negedge clk);
               rsp_valid = 0; rsp_shared = 0;
            end
            idx++;
         end else begin
            @(negedge clk);
         end
      end
      chk({tg, " completed"}, 32'(got), 1);
      chk({tg, " bus transaction count"}, 32'(idx), 32'(n));
      if (chk_rd) chk({tg, " read data"}, 32'(rd), 32'(erd));
      @(negedge clk);
      chk({tg, " R12 ready is one cycle"}, 32'(cpu_ready), 0);
   endtask

   task automatic access(input logic we, input logic [5:0] a, input logic [15:0] wd, input logic sh,
                         input int n, input logic [2:0] c0, input logic [2:0] c1,
                         input logic chk_rd, input logic [15:0] erd, input string tg);
      pulse_req(we, a, wd);
      complete(sh, n, c0, c1, chk_rd, erd, tg);
   endtask

   task automatic snoop(input logic [2:0] c, input logic [5:0] a, input logic esh, input logic edt,
                        input logic [15:0] ed, input string tg);
      @(negedge clk);
      snp_valid = 1; snp_cmd = c; snp_addr = a;
      @(negedge clk);
      snp_valid = 0;
      for (int k = 1; k <= LAT; k++) begin
         if (k > 1) @(negedge clk);
         chk({tg, " R9 inhibit held"}, 32'(snp_inhibit), 1);
         chk({tg, " R9 no answer during inhibit"}, 32'({snp_shared, snp_dirty}), 0);
      end
      @(negedge clk);
      chk({tg, " R9 inhibit released"}, 32'(snp_inhibit), 0);
      chk({tg, " shared"}, 32'(snp_shared), 32'(esh));
      chk({tg, " dirty"}, 32'(snp_dirty), 32'(edt));
      if (edt) begin
         chk({tg, " flush data"}, 32'(snp_flush_data), 32'(ed));
         mem[a] = snp_flush_data;
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = init_val(i);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 cpu_ready", 32'(cpu_ready), 0);
      chk("R1 bus_req", 32'(bus_req), 0);
      chk("R1 snoop outputs", 32'({snp_inhibit, snp_shared, snp_dirty}), 0);
      rst_n = 1;
      @(negedge clk);

      // R1/R2: fills on every set, shared answer alternating; then R3 read hits
      for (int s = 0; s < 4; s++)
         access(0, 6'(s), '0, s[0], 1, RD, NONE, 1, init_val(s), $sformatf("R1 R2 read miss set %0d", s));
      for (int s = 0; s < 4; s++)
         access(0, 6'(s), '0, 0, 0, NONE, NONE, 1, init_val(s), $sformatf("R3 read hit set %0d", s));

      // R3 silent E->M on even sets, R4 upgrade on odd (Shared) sets
      for (int s = 0; s < 4; s++)
         if (s[0]) access(1, 6'(s), 16'h5000 + 16'(s), 0, 1, UPGR, NONE, 0, '0, $sformatf("R4 write shared set %0d", s));
         else      access(1, 6'(s), 16'h5000 + 16'(s), 0, 0, NONE, NONE, 0, '0, $sformatf("R3 write exclusive set %0d", s));

      // R7: BusRd to Modified flushes and demotes; second BusRd sees a clean Shared copy
      for (int s = 0; s < 4; s++) begin
         snoop(RD, 6'(s), 1, 1, 16'h5000 + 16'(s), $sformatf("R7 BusRd on M set %0d", s));
         snoop(RD, 6'(s), 1, 0, '0, $sformatf("R7 BusRd on S set %0d", s));
      end

      // R8: BusRdX invalidates clean copies; refill sees flushed memory, lands Exclusive
      for (int s = 0; s < 4; s++) begin
         snoop(RDX, 6'(s), 0, 0, '0, $sformatf("R8 BusRdX on S set %0d", s));
         access(0, 6'(s), '0, 0, 1, RD, NONE, 1, 16'h5000 + 16'(s), $sformatf("R8 refill set %0d", s));
      end

      // R6: write miss (set 1, tag 1) over a clean victim
      access(1, 6'd5, 16'h6555, 0, 1, RDX, NONE, 0, '0, "R6 write miss");
      snoop(RD, 6'd5, 1, 1, 16'h6555, "R6 merged data is Modified");

      // R11: dirty victim written back before the fill
      access(1, 6'd2, 16'h6222, 0, 0, NONE, NONE, 0, '0, "R3 silent write set 2");
      access(0, 6'd6, '0, 0, 2, WB, RD, 1, init_val(6), "R11 dirty victim miss");
      chk("R11 victim data reached memory", 32'(mem[2]), 32'h6222);
      snoop(RD, 6'd2, 0, 0, '0, "R11 victim no longer held");

      // R8: BusRdX on Modified flushes and invalidates
      access(1, 6'd6, 16'h6666, 0, 0, NONE, NONE, 0, '0, "R3 silent write set 2 tag 1");
      snoop(RDX, 6'd6, 0, 1, 16'h6666, "R8 BusRdX on M");
      access(0, 6'd6, '0, 0, 1, RD, NONE, 1, 16'h6666, "R8 line was invalidated");

      // R5: pending upgrade loses the race
      snoop(RD, 6'd3, 1, 0, '0, "R7 BusRd on E set 3");
      pulse_req(1, 6'd3, 16'h7333);
      wait_bus_req();
      chk("R4 pending upgrade command", 32'(out_cmd), 32'(UPGR));
      snoop(RD, 6'd3, 1, 0, '0, "R4 R10 no ownership before grant");
      snoop(UPGR, 6'd3, 0, 0, '0, "R5 competing upgrade");
      chk("R5 pending request became BusRdX", 32'(out_cmd), 32'(RDX));
      complete(0, 1, RDX, NONE, 0, '0, "R5 converted request");
      snoop(RD, 6'd3, 1, 1, 16'h7333, "R5 write landed after BusRdX");

      // R4: upgrade that wins
      snoop(RD, 6'd0, 1, 0, '0, "R7 BusRd on E set 0");
      access(1, 6'd0, 16'h7000, 0, 1, UPGR, NONE, 0, '0, "R4 upgrade granted");
      snoop(RD, 6'd0, 1, 1, 16'h7000, "R4 owned after grant");

      // R10/R11: snoop cleans the dirty victim while the write-back waits
      access(1, 6'd5, 16'h7555, 0, 1, UPGR, NONE, 0, '0, "R4 upgrade set 1");
      pulse_req(0, 6'd9, '0);
      wait_bus_req();
      chk("R11 victim write-back pending", 32'(out_cmd), 32'(WB));
      snoop(RD, 6'd5, 1, 1, 16'h7555, "R10 snoop served while waiting");
      chk("R10 write-back dropped after flush", 32'(out_cmd), 32'(RD));
      complete(0, 1, RD, NONE, 1, init_val(9), "R10 fill after snoop");
      chk("R10 flushed data in memory", 32'(mem[5]), 32'h7555);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule